// File: doc/BRIEF.md
# Accumulator Arithmetic and Logic Unit

This block is the purely combinational compute stage of a small accumulator-based processor. The control sequencer presents it with the accumulator value, the data word just read from memory, the instruction's 8-bit operand field and the 8-bit opcode. In the same cycle the block returns the value the accumulator should take next and a write strobe that says whether the accumulator is to be updated.

The block also returns three condition flags: negative, positive and zero. The sequencer uses them to resolve conditional branches. The flags always describe the accumulator value presented at the input, never the candidate result, because a branch tests the accumulator as it stands.

Arithmetic wraps modulo 2^16 and produces no carry. The immediate add takes its operand from the instruction field instead of memory. The shifts take their distance from the low four bits of that field.

Top module: `acc_alu`

## Requirements
- R1: Opcode 8'h00 yields next_ac = ac + mdr, truncated to 16 bits (wraps modulo 2^16).
- R2: Opcode 8'h05 yields next_ac = ac - mdr, truncated to 16 bits (wraps modulo 2^16).
- R3: Opcode 8'h02 yields next_ac = mdr.
- R4: Opcodes 8'h06, 8'h07 and 8'h08 yield the bitwise XOR, OR and AND, respectively, of ac and mdr, each bit independent of the others.
- R5: Opcode 8'h0B yields next_ac = ac + field, with the 8-bit field zero-extended to 16 bits; mdr has no effect on the result.
- R6: Opcode 8'h0D shifts ac left by field[3:0] places and fills the vacated bits with zeros; field[7:4] has no effect.
- R7: Opcode 8'h0E shifts ac right by field[3:0] places and fills the vacated bits with zeros (logical shift); field[7:4] has no effect.
- R8: A shift opcode (8'h0D or 8'h0E) with field[3:0] = 0 returns ac unchanged.
- R9: ac_we is 1 exactly for opcodes 8'h00, 02, 05, 06, 07, 08, 0B, 0D and 0E. For every other opcode, ac_we is 0 and next_ac equals ac.
- R10: neg is 1 exactly when bit 15 of ac is 1 (ac taken as two's complement), whatever the opcode.
- R11: zero is 1 exactly when ac = 0, and pos is 1 exactly when bit 15 of ac is 0 and ac is nonzero; exactly one of neg, pos and zero is 1 at any time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ac_i | input | 16 | Current accumulator value |
| mdr_i | input | 16 | Data word read from memory |
| field_i | input | 8 | Instruction operand field (immediate or shift distance) |
| opcode_i | input | 8 | Instruction opcode |
| next_ac_o | output | 16 | Candidate new accumulator value |
| ac_we_o | output | 1 | Accumulator write strobe |
| neg_o | output | 1 | Accumulator is negative |
| pos_o | output | 1 | Accumulator is greater than zero |
| zero_o | output | 1 | Accumulator is zero |

## Verification
Every output of this block is due in the same cycle as its inputs, because no register lies on any path. The driver task applies a new operand set just after a rising edge and pushes the expected result, strobe and flags into the scoreboard queue. The monitor pops that item at the following falling edge, which is half a period later and well after the combinational outputs have settled. The next stimulus does not arrive until the next rising edge, so each comparison sees the result of exactly one operand set.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

   localparam int OPC_W = 8;

   localparam logic [OPC_W-1:0] OPC_ADD  = 8'h00;
   localparam logic [OPC_W-1:0] OPC_STO  = 8'h01;
   localparam logic [OPC_W-1:0] OPC_LDA  = 8'h02;
   localparam logic [OPC_W-1:0] OPC_JMP  = 8'h03;
   localparam logic [OPC_W-1:0] OPC_JNG  = 8'h04;
   localparam logic [OPC_W-1:0] OPC_SUB  = 8'h05;
   localparam logic [OPC_W-1:0] OPC_XOR  = 8'h06;
   localparam logic [OPC_W-1:0] OPC_OR   = 8'h07;
   localparam logic [OPC_W-1:0] OPC_AND  = 8'h08;
   localparam logic [OPC_W-1:0] OPC_JPS  = 8'h09;
   localparam logic [OPC_W-1:0] OPC_JZR  = 8'h0A;
   localparam logic [OPC_W-1:0] OPC_ADDI = 8'h0B;
   localparam logic [OPC_W-1:0] OPC_DSP  = 8'h0C;
   localparam logic [OPC_W-1:0] OPC_SHL  = 8'h0D;
   localparam logic [OPC_W-1:0] OPC_SHR  = 8'h0E;

   typedef enum logic [2:0] {
      SEL_HOLD,
      SEL_ARITH,
      SEL_PASS,
      SEL_XOR,
      SEL_OR,
      SEL_AND,
      SEL_SHIFT
   } res_sel_e;

   typedef struct packed {
      res_sel_e sel;
      logic     use_imm;
      logic     subtract;
      logic     shift_right;
      logic     we;
   } alu_ctl_t;

endpackage

// File: rtl/acc_alu_decode.sv
module acc_alu_decode
   import acc_alu_pkg::*;
(
   input  logic [OPC_W-1:0] opcode,
   output alu_ctl_t         ctl
);

   always_comb begin
      ctl = '{sel: SEL_HOLD, use_imm: 1'b0, subtract: 1'b0, shift_right: 1'b0, we: 1'b0};
      unique case (opcode)
         OPC_ADD:  begin ctl.sel = SEL_ARITH; ctl.we = 1'b1; end
         OPC_SUB:  begin ctl.sel = SEL_ARITH; ctl.subtract = 1'b1; ctl.we = 1'b1; end
         OPC_ADDI: begin ctl.sel = SEL_ARITH; ctl.use_imm = 1'b1; ctl.we = 1'b1; end
         OPC_LDA:  begin ctl.sel = SEL_PASS;  ctl.we = 1'b1; end
         OPC_XOR:  begin ctl.sel = SEL_XOR;   ctl.we = 1'b1; end
         OPC_OR:   begin ctl.sel = SEL_OR;    ctl.we = 1'b1; end
         OPC_AND:  begin ctl.sel = SEL_AND;   ctl.we = 1'b1; end
         OPC_SHL:  begin ctl.sel = SEL_SHIFT; ctl.we = 1'b1; end
         OPC_SHR:  begin ctl.sel = SEL_SHIFT; ctl.shift_right = 1'b1; ctl.we = 1'b1; end
         default:  ;
      endcase
   end

endmodule

// File: rtl/acc_alu_adder.sv
module acc_alu_adder #(
   parameter int W = 16
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         subtract,
   output logic [W-1:0] sum
);

   logic [W-1:0] b_eff;

   always_comb begin
      b_eff = b ^ {W{subtract}};
      sum   = a + b_eff + W'(subtract);
   end

endmodule

// File: rtl/acc_alu_shifter.sv
module acc_alu_shifter #(
   parameter int W      = 16,
   parameter int AMT_W  = 4,
   parameter bit BARREL = 1'b1
) (
   input  logic [W-1:0]     din,
   input  logic [AMT_W-1:0] amt,
   input  logic             to_right,
   output logic [W-1:0]     dout
);

   generate
      if (BARREL) begin : g_barrel
         logic [W-1:0] stage [0:AMT_W];
         assign stage[0] = din;
         for (genvar i = 0; i < AMT_W; i++) begin : g_stage
            localparam int DIST = 1 << i;
            assign stage[i+1] = !amt[i] ? stage[i]
                              : (to_right ? (stage[i] >> DIST) : (stage[i] << DIST));
         end
         assign dout = stage[AMT_W];
      end else begin : g_flat
         assign dout = to_right ? (din >> amt) : (din << amt);
      end
   endgenerate

endmodule

// File: rtl/acc_alu_flags.sv
module acc_alu_flags #(
   parameter int W = 16
) (
   input  logic [W-1:0] value,
   output logic         neg,
   output logic         pos,
   output logic         zero
);

   always_comb begin
      neg  = value[W-1];
      zero = (value == '0);
      pos  = !neg && !zero;
   end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
   import acc_alu_pkg::*;
#(
   parameter int DATA_W       = 16,
   parameter int FIELD_W      = 8,
   parameter int SHAMT_W      = 4,
   parameter bit BARREL_SHIFT = 1'b1
) (
   input  logic [DATA_W-1:0]  ac_i,
   input  logic [DATA_W-1:0]  mdr_i,
   input  logic [FIELD_W-1:0] field_i,
   input  logic [OPC_W-1:0]   opcode_i,
   output logic [DATA_W-1:0]  next_ac_o,
   output logic               ac_we_o,
   output logic               neg_o,
   output logic               pos_o,
   output logic               zero_o
);

   localparam int MAX_SHAMT = (1 << SHAMT_W) - 1;

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("acc_alu: DATA_W must be at least 2");
      end
      if (FIELD_W > DATA_W) begin : g_bad_field
         $error("acc_alu: FIELD_W must not exceed DATA_W");
      end
      if (SHAMT_W > FIELD_W) begin : g_bad_shamt
         $error("acc_alu: SHAMT_W must fit inside the operand field");
      end
      if (MAX_SHAMT >= DATA_W) begin : g_bad_range
         $error("acc_alu: shift range must stay below DATA_W");
      end
   endgenerate

   alu_ctl_t          ctl;
   logic [DATA_W-1:0] operand_b;
   logic [DATA_W-1:0] arith_res;
   logic [DATA_W-1:0] shift_res;

   acc_alu_decode u_decode (
      .opcode (opcode_i),
      .ctl    (ctl)
   );

   assign operand_b = ctl.use_imm ? DATA_W'(field_i) : mdr_i;

   acc_alu_adder #(.W(DATA_W)) u_adder (
      .a        (ac_i),
      .b        (operand_b),
      .subtract (ctl.subtract),
      .sum      (arith_res)
   );

   acc_alu_shifter #(.W(DATA_W), .AMT_W(SHAMT_W), .BARREL(BARREL_SHIFT)) u_shifter (
      .din      (ac_i),
      .amt      (field_i[SHAMT_W-1:0]),
      .to_right (ctl.shift_right),
      .dout     (shift_res)
   );

   acc_alu_flags #(.W(DATA_W)) u_flags (
      .value (ac_i),
      .neg   (neg_o),
      .pos   (pos_o),
      .zero  (zero_o)
   );

   always_comb begin
      unique case (ctl.sel)
         SEL_ARITH: next_ac_o = arith_res;
         SEL_PASS:  next_ac_o = mdr_i;
         SEL_XOR:   next_ac_o = ac_i ^ mdr_i;
         SEL_OR:    next_ac_o = ac_i | mdr_i;
         SEL_AND:   next_ac_o = ac_i & mdr_i;
         SEL_SHIFT: next_ac_o = shift_res;
         default:   next_ac_o = ac_i;
      endcase
   end

   assign ac_we_o = ctl.we;

endmodule

// File: rtl/acc_alu_checker.sv
module acc_alu_checker
   import acc_alu_pkg::*;
#(
   parameter int DATA_W  = 16,
   parameter int FIELD_W = 8,
   parameter int SHAMT_W = 4
) (
   input logic [DATA_W-1:0]  ac_i,
   input logic [DATA_W-1:0]  mdr_i,
   input logic [FIELD_W-1:0] field_i,
   input logic [OPC_W-1:0]   opcode_i,
   input logic [DATA_W-1:0]  next_ac_o,
   input logic               ac_we_o,
   input logic               neg_o,
   input logic               pos_o,
   input logic               zero_o
);

   logic is_shift;
   assign is_shift = (opcode_i == OPC_SHL) || (opcode_i == OPC_SHR);

   always_comb begin
      assert_one_flag_R11: assert final ($countones({neg_o, pos_o, zero_o}) == 1);
      if (zero_o)
         assert_zero_means_empty_R11: assert final (ac_i == '0);
      if (neg_o)
         assert_neg_sign_R10: assert final (ac_i[DATA_W-1]);
      if (!ac_we_o)
         assert_hold_when_idle_R9: assert final (next_ac_o == ac_i);
      if (opcode_i == OPC_LDA)
         assert_load_passes_R3: assert final (next_ac_o == mdr_i);
      if (opcode_i == OPC_AND)
         assert_and_subset_R4: assert final ((next_ac_o & ~ac_i) == '0);
      if (is_shift && field_i[SHAMT_W-1:0] == '0)
         assert_zero_shift_R8: assert final (next_ac_o == ac_i);
   end

endmodule

bind acc_alu acc_alu_checker #(
   .DATA_W (DATA_W),
   .FIELD_W(FIELD_W),
   .SHAMT_W(SHAMT_W)
) u_checker (
   .ac_i      (ac_i),
   .mdr_i     (mdr_i),
   .field_i   (field_i),
   .opcode_i  (opcode_i),
   .next_ac_o (next_ac_o),
   .ac_we_o   (ac_we_o),
   .neg_o     (neg_o),
   .pos_o     (pos_o),
   .zero_o    (zero_o)
);

// File: tb/tb_acc_alu.sv
module tb_acc_alu;

   typedef struct packed {
      logic [15:0] ac;
      logic        we;
      logic        neg;
      logic        pos;
      logic        zero;
      logic [63:0] tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [15:0] ac_i = '0, mdr_i = '0;
   logic [7:0]  field_i = '0, opcode_i = '0;
   logic [15:0] next_ac_o;
   logic        ac_we_o, neg_o, pos_o, zero_o;

   int   n_tests = 0;
   int   n_fail  = 0;
   bit   done    = 1'b0;
   exp_t sb_q[$];

   always #10 clk = ~clk;

   acc_alu dut (
      .ac_i     (ac_i),
      .mdr_i    (mdr_i),
      .field_i  (field_i),
      .opcode_i (opcode_i),
      .next_ac_o(next_ac_o),
      .ac_we_o  (ac_we_o),
      .neg_o    (neg_o),
      .pos_o    (pos_o),
      .zero_o   (zero_o)
   );

   function automatic exp_t model(input logic [15:0] a, input logic [15:0] m,
                                  input logic [7:0] f, input logic [7:0] op,
                                  input logic [63:0] tag);
      exp_t e;
      e.tag = tag;
      e.we  = 1'b1;
      case (op)
         8'h00: e.ac = a + m;
         8'h05: e.ac = a - m;
         8'h02: e.ac = m;
         8'h06: e.ac = a ^ m;
         8'h07: e.ac = a | m;
         8'h08: e.ac = a & m;
         8'h0B: e.ac = a + {8'h00, f};
         8'h0D: e.ac = a << f[3:0];
         8'h0E: e.ac = a >> f[3:0];
         default: begin e.ac = a; e.we = 1'b0; end
      endcase
      e.neg  = a[15];
      e.zero = (a == 16'h0000);
      e.pos  = !a[15] && (a != 16'h0000);
      return e;
   endfunction

   task automatic drive(input logic [15:0] a, input logic [15:0] m,
                        input logic [7:0] f, input logic [7:0] op,
                        input logic [63:0] tag);
      @(posedge clk);
      ac_i = a; mdr_i = m; field_i = f; opcode_i = op;
      sb_q.push_back(model(a, m, f, op, tag));
   endtask

   always @(negedge clk) begin
      if (sb_q.size() > 0) begin
         exp_t e;
         e = sb_q.pop_front();
         n_tests++;
         if (next_ac_o !== e.ac || ac_we_o !== e.we || neg_o !== e.neg ||
             pos_o !== e.pos || zero_o !== e.zero) begin
            n_fail++;
            $display("FAIL %s: op=%h ac=%h mdr=%h f=%h got ac=%h we=%b n/p/z=%b%b%b exp ac=%h we=%b n/p/z=%b%b%b",
                     e.tag, opcode_i, ac_i, mdr_i, field_i, next_ac_o, ac_we_o,
                     neg_o, pos_o, zero_o, e.ac, e.we, e.neg, e.pos, e.zero);
         end
      end
   end

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL all: watchdog expired, got done=0 exp done=1");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin : stim
      repeat (3) @(posedge clk);
      rst = 1'b0;
      // Reset state: all-zero inputs give the add of zeros with the zero flag
      drive(16'h0000, 16'h0000, 8'h00, 8'h00, "R11 rst");
      drive(16'h1234, 16'h0101, 8'h00, 8'h00, "R1");
      drive(16'hFFFF, 16'h0002, 8'h00, 8'h00, "R1 wrap");
      drive(16'h0005, 16'h0007, 8'h00, 8'h05, "R2 wrap");
      drive(16'h8000, 16'h0001, 8'h00, 8'h05, "R2");
      drive(16'h7777, 16'hBEEF, 8'h00, 8'h02, "R3");
      drive(16'hF0F0, 16'hFF00, 8'h00, 8'h06, "R4 xor");
      drive(16'hF0F0, 16'h0F0F, 8'h00, 8'h07, "R4 or");
      drive(16'hF0F0, 16'hFF00, 8'h00, 8'h08, "R4 and");
      drive(16'h00F0, 16'h5555, 8'hFF, 8'h0B, "R5 zext");
      drive(16'hFFFF, 16'h0000, 8'h01, 8'h0B, "R5 wrap");
      drive(16'h8001, 16'h0000, 8'h04, 8'h0D, "R6");
      drive(16'h0001, 16'h0000, 8'hFF, 8'h0D, "R6 hi");
      drive(16'h8001, 16'h0000, 8'h04, 8'h0E, "R7");
      drive(16'hFFFF, 16'h0000, 8'hAF, 8'h0E, "R7 hi");
      drive(16'hA5A5, 16'h0000, 8'h00, 8'h0D, "R8 shl");
      drive(16'hA5A5, 16'h0000, 8'hF0, 8'h0E, "R8 shr");
      drive(16'h1357, 16'h2468, 8'h12, 8'h01, "R9 sto");
      drive(16'hFFFE, 16'h2468, 8'h12, 8'h04, "R9 jng");
      drive(16'h0000, 16'h2468, 8'h12, 8'h0A, "R9 jzr");
      drive(16'h4321, 16'h2468, 8'h12, 8'h0C, "R9 dsp");
      drive(16'h4321, 16'h2468, 8'h12, 8'hFF, "R9 ff");
      drive(16'h8000, 16'h0000, 8'h00, 8'h03, "R10");
      drive(16'h7FFF, 16'h0000, 8'h00, 8'h09, "R11 pos");
      drive(16'h0001, 16'h1111, 8'h00, 8'h00, "R11 one");
      for (int i = 0; i < 300; i++) begin
         logic [7:0] op;
         op = (i % 5 == 0) ? 8'($urandom_range(0, 255)) : 8'($urandom_range(0, 15));
         drive(16'($urandom), 16'($urandom), 8'($urandom), op, "R1 mix");
      end
      @(posedge clk);
      @(posedge clk);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule